// File: doc/BRIEF.md
# Multi-channel window threshold watchdog

This block supervises up to eight input channels. It compares each sample it accepts against a programmable upper limit and a programmable lower limit, and both limits are signed. Samples arrive on one of two streams. Each stream carries a valid strobe, a channel index and a data word. The fast stream carries per-channel filtered samples. The conversion stream carries the main conversion results. A single source-select setting decides which stream is compared, and the stream that is not selected is ignored entirely.

A per-channel enable mask decides which channels are supervised. When a supervised sample lies strictly above the upper limit, the block sets that channel's high flag. When it lies strictly below the lower limit, the block sets that channel's low flag. Flags stay set until software writes 1 to clear them. An interrupt line is raised while any flag is set and interrupts are enabled. A break line pulses once for every breaching sample. The fast stream is checked continuously, without regard to whether any main conversion is running, so channels stay supervised while main conversions are paused.

Software programs the block through simple write strobes with data: upper limit, lower limit, mask, source select, interrupt enable, and per-channel clear vectors.

Top module: `win_watchdog`

## Requirements
- R1: After reset all high and low flags are 0, irq is 0, brk is 0, and the channel mask is 0, so no channel is supervised until the mask is written.
- R2: A supervised sample whose signed value is strictly greater than the upper limit sets the high flag of its channel (bit = channel index) one clock later; a sample equal to the upper limit sets nothing.
- R3: A supervised sample whose signed value is strictly less than the lower limit sets the low flag of its channel one clock later; a sample equal to the lower limit sets nothing.
- R4: A sample on a channel whose mask bit is 0 sets no flag and produces no brk pulse.
- R5: With src_wdata written as 0 only the fast stream (flt_*) is compared and the conversion stream is ignored; with 1 only the conversion stream (res_*) is compared and the fast stream is ignored. The fast stream is compared on every valid sample and depends on no conversion activity.
- R6: When the conversion stream is selected, the channel index of each result is checked against the mask before the comparison.
- R7: Flags are sticky; writing 1 to a bit of clr_hi or clr_lo clears that flag at the next clock, but a breach that sets the same flag in the same cycle as its clear leaves the flag set.
- R8: irq is high exactly when the interrupt enable (written through ien_we) is 1 and at least one high or low flag is set; the enable resets to 0.
- R9: brk is high for one clock cycle, the cycle after each breaching sample, and low otherwise.
- R10: After reset the upper limit is the largest positive value of the data width and the lower limit is the most negative one, so no sample can breach either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_we | input | 1 | Write strobe for the upper limit |
| hi_wdata | input | DW | Upper limit value, signed |
| lo_we | input | 1 | Write strobe for the lower limit |
| lo_wdata | input | DW | Lower limit value, signed |
| mask_we | input | 1 | Write strobe for the channel mask |
| mask_wdata | input | NCH | Channel mask; bit n enables channel n |
| src_we | input | 1 | Write strobe for the source select |
| src_wdata | input | 1 | 0 selects the fast stream, 1 selects the conversion stream |
| ien_we | input | 1 | Write strobe for the interrupt enable |
| ien_wdata | input | 1 | Interrupt enable value |
| clr_hi | input | NCH | Write-1-to-clear strobes for the high flags |
| clr_lo | input | NCH | Write-1-to-clear strobes for the low flags |
| flt_valid | input | 1 | Fast stream sample valid |
| flt_ch | input | CHW | Fast stream channel index |
| flt_data | input | DW | Fast stream sample, signed |
| res_valid | input | 1 | Conversion stream result valid |
| res_ch | input | CHW | Conversion result channel index |
| res_data | input | DW | Conversion result, signed |
| hi_flags | output | NCH | Sticky high-breach flags, one per channel |
| lo_flags | output | NCH | Sticky low-breach flags, one per channel |
| irq | output | 1 | Interrupt request |
| brk | output | 1 | Break pulse |

## Verification
A sample presented in one cycle is compared combinationally and lands in the flag and brk registers at the following rising edge. The flags and brk are therefore due one clock after the sample, and irq follows the flags or the enable register in that same cycle with no further delay. Every bench task drives its inputs on the falling edge, waits for the next rising edge, and samples 1 ns later, once that single register stage has updated. brk is then sampled again one cycle later to confirm that it has dropped. A clear and a breach are driven in the same cycle to check which one wins.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int NCH = 8,
  parameter int DW  = 24,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hi_we,
  input  logic [DW-1:0]  hi_wdata,
  input  logic           lo_we,
  input  logic [DW-1:0]  lo_wdata,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_wdata,
  input  logic           src_we,
  input  logic           src_wdata,
  input  logic           ien_we,
  input  logic           ien_wdata,
  input  logic [NCH-1:0] clr_hi,
  input  logic [NCH-1:0] clr_lo,
  input  logic           flt_valid,
  input  logic [CHW-1:0] flt_ch,
  input  logic [DW-1:0]  flt_data,
  input  logic           res_valid,
  input  logic [CHW-1:0] res_ch,
  input  logic [DW-1:0]  res_data,
  output logic [NCH-1:0] hi_flags,
  output logic [NCH-1:0] lo_flags,
  output logic           irq,
  output logic           brk
);

  localparam logic [DW-1:0] THR_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] THR_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] hi_thr, lo_thr;
  logic [NCH-1:0]       ch_mask;
  logic                 src_sel, irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_thr  <= THR_MAX;
      lo_thr  <= THR_MIN;
      ch_mask <= '0;
      src_sel <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (hi_we)   hi_thr  <= hi_wdata;
      if (lo_we)   lo_thr  <= lo_wdata;
      if (mask_we) ch_mask <= mask_wdata;
      if (src_we)  src_sel <= src_wdata;
      if (ien_we)  irq_en  <= ien_wdata;
    end
  end

  logic                 s_valid;
  logic [CHW-1:0]       s_ch;
  logic signed [DW-1:0] s_data;

  assign s_valid = src_sel ? res_valid : flt_valid;
  assign s_ch    = src_sel ? res_ch    : flt_ch;
  assign s_data  = src_sel ? res_data  : flt_data;

  logic over, under;
  assign over  = s_data > hi_thr;
  assign under = s_data < lo_thr;

  logic [NCH-1:0] ch_hit, set_hi, set_lo;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign ch_hit[g] = s_valid && (s_ch == CHW'(g)) && ch_mask[g];
    assign set_hi[g] = ch_hit[g] && over;
    assign set_lo[g] = ch_hit[g] && under;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_flags[g] <= 1'b0;
        lo_flags[g] <= 1'b0;
      end else begin
        hi_flags[g] <= (hi_flags[g] && !clr_hi[g]) || set_hi[g];
        lo_flags[g] <= (lo_flags[g] && !clr_lo[g]) || set_lo[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk <= 1'b0;
    else        brk <= |{set_hi, set_lo};
  end

  assign irq = irq_en && (|{hi_flags, lo_flags});

endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] hi_flags,
  input logic [NCH-1:0] lo_flags,
  input logic [NCH-1:0] clr_hi,
  input logic [NCH-1:0] clr_lo,
  input logic [NCH-1:0] set_hi,
  input logic [NCH-1:0] set_lo,
  input logic           irq_en,
  input logic           irq,
  input logic           brk
);

  for (genvar g = 0; g < NCH; g++) begin : g_ck
    assert_sticky_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_flags[g] && !clr_hi[g]) |=> hi_flags[g]);
    assert_sticky_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_flags[g] && !clr_lo[g]) |=> lo_flags[g]);
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hi[g] || set_lo[g]) |=> ((hi_flags[g] || !$past(set_hi[g])) && (lo_flags[g] || !$past(set_lo[g]))));
    assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_flags[g]) |-> $past(set_hi[g]));
  end

  assert_brk_after_breach_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|{set_hi, set_lo}) |=> brk);
  assert_brk_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{set_hi, set_lo}) |=> !brk);
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|{hi_flags, lo_flags}));
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

endmodule

bind win_watchdog win_watchdog_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .hi_flags(hi_flags), .lo_flags(lo_flags),
  .clr_hi(clr_hi), .clr_lo(clr_lo), .set_hi(set_hi), .set_lo(set_lo),
  .irq_en(irq_en), .irq(irq), .brk(brk)
);

// File: tb/win_watchdog_tb_top.sv
`timescale 1ns/1ps
module win_watchdog_tb_top;
  localparam int NCH = 8;
  localparam int DW  = 24;
  localparam int CHW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_we = 0, lo_we = 0, mask_we = 0, src_we = 0, ien_we = 0;
  logic [DW-1:0] hi_wdata = '0, lo_wdata = '0;
  logic [NCH-1:0] mask_wdata = '0, clr_hi = '0, clr_lo = '0;
  logic src_wdata = 0, ien_wdata = 0;
  logic flt_valid = 0, res_valid = 0;
  logic [CHW-1:0] flt_ch = '0, res_ch = '0;
  logic [DW-1:0] flt_data = '0, res_data = '0;
  logic [NCH-1:0] hi_flags, lo_flags;
  logic irq, brk;

  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  win_watchdog #(.NCH(NCH), .DW(DW)) dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic wr_hi(int v);
    @(negedge clk); hi_we = 1; hi_wdata = DW'(v); settle(); hi_we = 0;
  endtask
  task automatic wr_lo(int v);
    @(negedge clk); lo_we = 1; lo_wdata = DW'(v); settle(); lo_we = 0;
  endtask
  task automatic wr_mask(logic [NCH-1:0] v);
    @(negedge clk); mask_we = 1; mask_wdata = v; settle(); mask_we = 0;
  endtask
  task automatic wr_src(logic v);
    @(negedge clk); src_we = 1; src_wdata = v; settle(); src_we = 0;
  endtask
  task automatic wr_ien(logic v);
    @(negedge clk); ien_we = 1; ien_wdata = v; settle(); ien_we = 0;
  endtask
  task automatic clear_all();
    @(negedge clk); clr_hi = '1; clr_lo = '1; settle(); clr_hi = '0; clr_lo = '0;
  endtask

  // drives one sample; returns after the flag/brk register stage has updated
  task automatic send(bit on_res, int ch, int v);
    @(negedge clk);
    if (on_res) begin res_valid = 1; res_ch = CHW'(ch); res_data = DW'(v); end
    else        begin flt_valid = 1; flt_ch = CHW'(ch); flt_data = DW'(v); end
    settle();
    res_valid = 0; flt_valid = 0;
  endtask

  task automatic t_reset();
    check("R1 hi_flags", 32'(hi_flags), 0);
    check("R1 lo_flags", 32'(lo_flags), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 brk", 32'(brk), 0);
    send(0, 0, 32'h7FFFFF); wr_hi(0);
    send(0, 0, 5);
    check("R1 mask zero ignores", 32'(hi_flags), 0);
    wr_hi(32'h7FFFFF);
  endtask

  task automatic t_limits_default();
    wr_mask(8'hFF);
    send(0, 2, 32'h7FFFFF);
    check("R10 max sample", 32'({hi_flags, lo_flags}), 0);
    send(0, 2, 32'h800000);
    check("R10 min sample", 32'({hi_flags, lo_flags}), 0);
    check("R10 brk", 32'(brk), 0);
  endtask

  task automatic t_high();
    wr_hi(100);
    send(0, 1, 100);
    check("R2 equal no breach", 32'(hi_flags), 0);
    send(0, 1, 101);
    check("R2 above", 32'(hi_flags), 32'h02);
    check("R9 brk high", 32'(brk), 1);
    settle();
    check("R9 brk one cycle", 32'(brk), 0);
    check("R2 sticky", 32'(hi_flags), 32'h02);
  endtask

  task automatic t_low();
    wr_lo(-100);
    send(0, 3, -100);
    check("R3 equal no breach", 32'(lo_flags), 0);
    send(0, 3, -101);
    check("R3 below", 32'(lo_flags), 32'h08);
    check("R3 no high", 32'(hi_flags), 32'h02);
  endtask

  task automatic t_irq();
    check("R8 disabled", 32'(irq), 0);
    wr_ien(1);
    check("R8 enabled", 32'(irq), 1);
  endtask

  task automatic t_clear();
    @(negedge clk); clr_hi = 8'h02; settle(); clr_hi = '0;
    check("R7 w1c", 32'(hi_flags), 0);
    check("R7 other kept", 32'(lo_flags), 32'h08);
    @(negedge clk);
    clr_lo = 8'h08; flt_valid = 1; flt_ch = 3; flt_data = DW'(-500);
    settle();
    clr_lo = '0; flt_valid = 0;
    check("R7 set beats clear", 32'(lo_flags), 32'h08);
    clear_all();
    check("R7 all clear", 32'({hi_flags, lo_flags}), 0);
    check("R8 irq drops", 32'(irq), 0);
  endtask

  task automatic t_mask();
    wr_mask(8'hFE);
    send(0, 0, 1000);
    check("R4 masked flag", 32'(hi_flags), 0);
    check("R4 masked brk", 32'(brk), 0);
    send(0, 5, 1000);
    check("R4 enabled chan", 32'(hi_flags), 32'h20);
    clear_all();
  endtask

  task automatic t_source();
    wr_mask(8'hFF);
    send(1, 6, 1000);
    check("R5 res ignored", 32'(hi_flags), 0);
    check("R5 res ignored brk", 32'(brk), 0);
    send(0, 6, 1000);
    check("R5 flt used", 32'(hi_flags), 32'h40);
    clear_all();
    wr_src(1);
    send(0, 7, 1000);
    check("R5 flt ignored", 32'(hi_flags), 0);
    send(1, 7, -1000);
    check("R5 res used", 32'(lo_flags), 32'h80);
    clear_all();
    wr_mask(8'h7F);
    send(1, 7, 1000);
    check("R6 res masked", 32'(hi_flags), 0);
    send(1, 4, 1000);
    check("R6 res enabled", 32'(hi_flags), 32'h10);
    clear_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_limits_default();
    t_high();
    t_low();
    t_irq();
    t_clear();
    t_mask();
    t_source();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule